// File: doc/BRIEF.md
# DMA Byte Counter and End-of-Transfer Controller

This block paces the DMA data path of a full-speed USB peripheral. A host CPU programs it one byte at a time. It writes a 16-bit transfer byte count and a configuration word. The configuration word holds a run enable, a burst-size select, a 4-bit endpoint index, and two end-of-transfer (EOT) source enables: one for terminal count and one for a short or empty OUT packet. Once running, the block asks an external DMA master for bursts of bytes. It moves one byte on each cycle where its request and the master's acknowledge are both high.

The block keeps a live remaining-byte counter that is separate from the programmed count. The counter is reloaded only when the run enable goes from 0 to 1, so the programmed count survives any number of transfers. A transfer ends with a one-cycle `eot` pulse in three cases: the counter reaches zero with count-EOT enabled, a short packet is reported with short-packet EOT enabled, or software clears the enable. A USB bus reset stops the transfer without an EOT pulse and keeps every setting except the enable. The endpoint buffer is modelled as a fill or space level.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the remaining count and the configuration readback are 0, and `dreq` and `eot` are low.
- R2: The count register is loaded from two byte writes. `wr_sel`=0 stages the low byte and `wr_sel`=1 supplies the high byte and commits all 16 bits. A low-byte write alone leaves the count used by the next reload unchanged.
- R3: With `rd_sel`=0, `rd_data` is the live remaining count. With `rd_sel`=1, `rd_data` is the configuration word: bit 0 run, bits 2:1 burst select, bits 7:4 endpoint, bit 8 count-EOT enable, bit 9 short-packet EOT enable, all other bits 0.
- R4: `wr_sel`=2 stages the low configuration byte: bit 0 enable, bits 2:1 burst select, bits 7:4 endpoint. `wr_sel`=3 writes the high byte (bit 0 count-EOT enable, bit 1 short-packet EOT enable) and commits the whole word. An enable change from 0 to 1 at the commit reloads the remaining count from the count register.
- R5: Burst select 0, 1, 2 and 3 requests 1, 4, 8 and 16 bytes. The last burst is cut to the remaining count. With `dack` held high, `dreq` stays high for exactly one burst length.
- R6: A burst starts only while running with a nonzero remaining count, and only when `ep_level` is at least the length of that burst.
- R7: Each cycle with `dreq` and `dack` both high moves one byte and lowers the remaining count by one. The count never wraps below zero.
- R8: With count-EOT enabled, reaching a remaining count of zero gives a single-cycle `eot` and clears run. With count-EOT disabled, the block stays running at zero with no `eot` and no further requests.
- R9: A `short_pkt` pulse while running, with short-packet EOT enabled, gives `eot` and clears run. With short-packet EOT disabled, the pulse has no effect.
- R10: Committing enable=0 while running drops `dreq` at the next edge and gives one `eot` pulse. The remaining count keeps the bytes not yet moved.
- R11: `bus_reset` clears run and `dreq` without an `eot` pulse. It keeps the count register, burst select, endpoint and both EOT enables.
- R12: `dma_ep` always shows the committed endpoint index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset pulse |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 2 | Byte select: 0 count low, 1 count high, 2 config low, 3 config high |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Readback select: 0 remaining count, 1 configuration word |
| rd_data | output | 16 | Readback value |
| ep_level | input | 8 | Bytes of data or space the endpoint buffer reports |
| short_pkt | input | 1 | Short or empty OUT packet received (pulse) |
| dack | input | 1 | DMA master acknowledge, one byte per cycle |
| dreq | output | 1 | DMA request, held for the burst |
| dma_ep | output | 4 | Endpoint index targeted by the DMA |
| eot | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check the following on every cycle:
- The count register changes only on a high-byte write.
- The remaining counter never wraps.
- An outstanding burst never exceeds the remaining count.
- `dreq` is never high while stopped.
- `eot` lasts one cycle and always comes with run cleared.
- A bus reset always leaves the block stopped with no `eot`.

The bench scenarios show the rest:
- Burst lengths and last-burst trimming for every burst select, over a set of counts.
- Byte totals matching the programmed count.
- The effect of endpoint level on when bursts start.
- Which EOT sources fire under which enables.
- That settings survive a bus reset and a torn count write.

// File: rtl/dma_eot_pkg.sv
// Shared types and helpers for the DMA byte counter / EOT controller.
// Assumes burst lengths are fixed at 1, 4, 8 and 16 bytes.
package dma_eot_pkg;

    localparam int EP_W = 4;
    localparam int BL_W = 5;   // holds a burst length up to 16

    // Register byte selects on the write port
    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CFG_LO = 2'd2,
        SEL_CFG_HI = 2'd3
    } wr_sel_e;

    // Committed configuration (run enable is kept by the run controller)
    typedef struct packed {
        logic            short_en;
        logic            cnt_en;
        logic [EP_W-1:0] ep;
        logic [1:0]      burst;
    } cfg_t;

    // Burst select to byte count
    function automatic logic [BL_W-1:0] burst_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    burst_bytes = BL_W'(1);
            2'd1:    burst_bytes = BL_W'(4);
            2'd2:    burst_bytes = BL_W'(8);
            default: burst_bytes = BL_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/dma_regfile.sv
// Byte-wide register file for the count and configuration words.
// Low bytes are staged; the high-byte write commits the full word, so no
// half-updated value is ever visible. Bus reset does not touch this block.
module dma_regfile
    import dma_eot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count_reg,
    output cfg_t             cfg,
    output logic             en_wr,    // config commit strobe this cycle
    output logic             en_val    // enable value carried by the commit
);

    localparam int HI_W = CNT_W - 8;

    logic [7:0] cnt_lo_stage;
    logic [6:0] cfg_lo_stage;   // {ep[3:0], burst[1:0], enable}
    wr_sel_e    sel;

    assign sel    = wr_sel_e'(wr_sel);
    assign en_wr  = wr_en && (sel == SEL_CFG_HI);
    assign en_val = cfg_lo_stage[0];

    // Stage low bytes and commit whole words on high-byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo_stage <= '0;
            cfg_lo_stage <= '0;
            count_reg    <= '0;
            cfg          <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CNT_LO: cnt_lo_stage <= wr_data;
                SEL_CNT_HI: count_reg    <= {wr_data[HI_W-1:0], cnt_lo_stage};
                SEL_CFG_LO: cfg_lo_stage <= {wr_data[7:4], wr_data[2:0]};
                default: begin
                    cfg.short_en <= wr_data[1];
                    cfg.cnt_en   <= wr_data[0];
                    cfg.ep       <= cfg_lo_stage[6:3];
                    cfg.burst    <= cfg_lo_stage[2:1];
                end
            endcase
        end
    end

    // The count word only moves on a high-byte commit
    assert_count_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> $stable(count_reg));

endmodule

// File: rtl/dma_down_counter.sv
// Remaining-byte counter. It reloads from the count register on a load
// pulse and counts down one per moved byte, holding at zero.
module dma_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem,
    output logic             rem_zero
);

    assign rem_zero = (rem == '0);

    // Reload on enable, else count moved bytes down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (dec && !rem_zero)
            rem <= rem - CNT_W'(1);
    end

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rem == '0 && !load) |=> rem == '0);

endmodule

// File: rtl/dma_run_ctl.sv
// Run enable and EOT generation. It picks among bus reset, a software
// enable commit, terminal count and a short packet, in that priority.
// Assumes short_pkt only comes from OUT endpoints.
module dma_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic en_wr,
    input  logic en_val,
    input  logic cnt_en,
    input  logic short_en,
    input  logic rem_zero,
    input  logic short_pkt,
    output logic run,
    output logic eot,
    output logic load,   // reload the remaining counter this cycle
    output logic stop    // run falls at this edge
);

    logic term;

    assign term = run && ((cnt_en && rem_zero) || (short_en && short_pkt));
    assign load = !bus_reset && en_wr && en_val && !run;
    assign stop = run && (bus_reset || (en_wr && !en_val) || (!en_wr && term));

    // Track the run state and emit a single EOT cycle on any ending but bus reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            eot <= 1'b0;
        end else if (bus_reset) begin
            run <= 1'b0;
            eot <= 1'b0;
        end else if (en_wr) begin
            run <= en_val;
            eot <= run && !en_val;
        end else if (term) begin
            run <= 1'b0;
            eot <= 1'b1;
        end else begin
            eot <= 1'b0;
        end
    end

    assert_eot_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);
    assert_eot_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> !run);
    assert_bus_reset_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!run && !eot));

endmodule

// File: rtl/dma_burst_seq.sv
// Request burst sequencer. It opens a burst of min(burst size, remaining)
// bytes when the endpoint level covers it, then holds dreq until that many
// bytes are acknowledged. It assumes one byte per dack cycle.
module dma_burst_seq
    import dma_eot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stop,
    input  logic [CNT_W-1:0] rem,
    input  logic [LVL_W-1:0] ep_level,
    input  logic [1:0]       burst_sel,
    input  logic             dack,
    output logic             dreq,
    output logic             take
);

    logic [BL_W-1:0]  burst_left;
    logic [BL_W-1:0]  full_len;
    logic [BL_W-1:0]  len;
    logic [CNT_W-1:0] full_len_w;
    logic             can_start;

    assign full_len   = burst_bytes(burst_sel);
    assign full_len_w = {{(CNT_W-BL_W){1'b0}}, full_len};

    // Cut the burst to the bytes left
    always_comb begin
        if (rem < full_len_w) len = rem[BL_W-1:0];
        else                  len = full_len;
    end

    assign can_start = run && (rem != '0)
                       && ({{(LVL_W-BL_W){1'b0}}, len} <= ep_level);
    assign dreq = (burst_left != '0);
    assign take = dreq && dack;

    // Open, count down, or cancel the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || stop)
            burst_left <= '0;
        else if (dreq)
            burst_left <= burst_left - BL_W'(take);
        else if (can_start)
            burst_left <= len;
    end

    assert_burst_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {{(CNT_W-BL_W){1'b0}}, burst_left} <= rem);
    assert_req_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> run);

endmodule

// File: rtl/dma_eot_ctrl.sv
// Top of the DMA byte counter / EOT controller. It joins the register file,
// run controller, remaining counter and burst sequencer, and muxes readback.
// Assumes the CPU write port and the DMA master share clk.
module dma_eot_ctrl
    import dma_eot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_sel,
    output logic [15:0]      rd_data,
    input  logic [LVL_W-1:0] ep_level,
    input  logic             short_pkt,
    input  logic             dack,
    output logic             dreq,
    output logic [EP_W-1:0]  dma_ep,
    output logic             eot
);

    logic [CNT_W-1:0] count_reg;
    logic [CNT_W-1:0] rem;
    cfg_t             cfg;
    logic             en_wr, en_val, run, load, stop, rem_zero, take;
    logic [15:0]      cfg_word;

    dma_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_reg(count_reg), .cfg(cfg),
        .en_wr(en_wr), .en_val(en_val)
    );

    dma_run_ctl u_run (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .en_wr(en_wr),
        .en_val(en_val), .cnt_en(cfg.cnt_en), .short_en(cfg.short_en),
        .rem_zero(rem_zero), .short_pkt(short_pkt), .run(run), .eot(eot),
        .load(load), .stop(stop)
    );

    dma_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(count_reg),
        .dec(take), .rem(rem), .rem_zero(rem_zero)
    );

    dma_burst_seq #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .run(run), .stop(stop), .rem(rem),
        .ep_level(ep_level), .burst_sel(cfg.burst), .dack(dack),
        .dreq(dreq), .take(take)
    );

    assign dma_ep   = cfg.ep;
    assign cfg_word = {6'b0, cfg.short_en, cfg.cnt_en, cfg.ep, 1'b0, cfg.burst, run};

    // Readback mux: live remaining count or configuration word
    always_comb begin
        if (rd_sel) rd_data = cfg_word;
        else        rd_data = 16'(rem);
    end

endmodule

// File: tb/tb_dma_eot_ctrl.sv
module tb_dma_eot_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, bus_reset = 1'b0, wr_en = 1'b0, rd_sel = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0, ep_level = 8'd0;
    logic        short_pkt = 1'b0, dack = 1'b0;
    logic [15:0] rd_data;
    logic        dreq, eot;
    logic [3:0]  dma_ep;

    int checks = 0, errors = 0;
    bit done = 0;

    // Monitor state
    bit chk_bursts = 0;
    int bytes = 0, cur = 0, left = 0, bsz = 1, eot_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_eot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ep_level(ep_level), .short_pkt(short_pkt), .dack(dack), .dreq(dreq),
        .dma_ep(dma_ep), .eot(eot)
    );

    function automatic int burst_of(input int s);
        return (s == 0) ? 1 : (4 << (s - 1));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Byte and burst monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dreq && dack) begin
                bytes++;
                cur++;
            end else if (cur > 0) begin
                if (chk_bursts) begin
                    int e;
                    e = (left < bsz) ? left : bsz;
                    chk("R5 burst length", cur, e);
                end
                left -= cur;
                cur = 0;
            end
            if (eot) eot_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic s, output int v);
        rd_sel = s;
        @(negedge clk);
        v = int'(rd_data);
        @(posedge clk); #1;
    endtask

    task automatic set_count(input int c);
        wr(2'd0, 8'(c));
        wr(2'd1, 8'(c >> 8));
    endtask

    // Stage config low (enable, burst, ep) then commit with the high byte
    task automatic set_cfg(input bit en, input int bs, input int ep, input bit cen, input bit sen);
        wr(2'd2, {4'(ep), 1'b0, 2'(bs), en});
        wr(2'd3, {6'b0, sen, cen});
    endtask

    task automatic clear_mon(input int c, input int bs, input bit chkb);
        bytes = 0; cur = 0; left = c; bsz = burst_of(bs); eot_cnt = 0; chk_bursts = chkb;
    endtask

    task automatic wait_eot(input int maxc);
        for (int i = 0; i < maxc && eot_cnt == 0; i++) cyc(1);
        cyc(3);
    endtask

    initial begin
        int v;
        int cnts[8] = '{0, 1, 3, 4, 5, 16, 17, 37};
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(1'b0, v); chk("R1 remaining after reset", v, 0);
        rd(1'b1, v); chk("R1 config after reset", v, 0);
        chk("R1 dreq after reset", int'(dreq), 0);
        chk("R1 eot after reset", int'(eot), 0);

        // R5 R7 R8 R3 R12 sweep of burst select and count
        ep_level = 8'd255; dack = 1'b1;
        for (int bs = 0; bs < 4; bs++) begin
            foreach (cnts[k]) begin
                int ep;
                ep = (bs * 5 + k) % 16;
                set_count(cnts[k]);
                clear_mon(cnts[k], bs, 1);
                set_cfg(1'b1, bs, ep, 1'b1, 1'b0);
                wait_eot(200);
                chk("R7 bytes moved", bytes, cnts[k]);
                chk("R8 one eot", eot_cnt, 1);
                chk("R5 all bursts accounted", left, 0);
                rd(1'b0, v); chk("R3 remaining readback", v, 0);
                rd(1'b1, v); chk("R3 config readback", v, (1 << 8) | (ep << 4) | (bs << 1));
                chk("R12 dma_ep", int'(dma_ep), ep);
            end
        end

        // R6 level gating, then trimmed last burst
        ep_level = 8'd3;
        set_count(8);
        clear_mon(8, 1, 1);
        set_cfg(1'b1, 1, 2, 1'b1, 1'b0);
        cyc(10);
        chk("R6 no request below burst length", int'(dreq), 0);
        rd(1'b0, v); chk("R6 remaining unchanged", v, 8);
        ep_level = 8'd4;
        wait_eot(100);
        chk("R6 bytes after level rises", bytes, 8);
        ep_level = 8'd6;
        set_count(6);
        clear_mon(6, 2, 1);
        set_cfg(1'b1, 2, 2, 1'b1, 1'b0);
        wait_eot(100);
        chk("R6 trimmed burst starts on level", bytes, 6);

        // R8 counter EOT disabled: stays running at zero
        ep_level = 8'd255;
        set_count(5);
        clear_mon(5, 0, 1);
        set_cfg(1'b1, 0, 1, 1'b0, 1'b0);
        cyc(30);
        chk("R8 bytes without count eot", bytes, 5);
        chk("R8 no eot when disabled", eot_cnt, 0);
        rd(1'b0, v); chk("R7 holds at zero", v, 0);
        rd(1'b1, v); chk("R8 still running", v & 1, 1);
        chk("R8 no request at zero", int'(dreq), 0);
        clear_mon(0, 0, 0);
        set_cfg(1'b0, 0, 1, 1'b0, 1'b0);
        cyc(3);
        chk("R10 abort at zero gives eot", eot_cnt, 1);

        // R9 short packet EOT, enabled then disabled
        ep_level = 8'd0;
        set_count(40);
        clear_mon(40, 3, 0);
        set_cfg(1'b1, 3, 6, 1'b1, 1'b1);
        cyc(2);
        short_pkt = 1'b1; cyc(1); short_pkt = 1'b0; cyc(3);
        chk("R9 short packet eot", eot_cnt, 1);
        rd(1'b1, v); chk("R9 run cleared", v & 1, 0);
        rd(1'b0, v); chk("R9 remaining kept", v, 40);
        clear_mon(40, 3, 0);
        set_cfg(1'b1, 3, 6, 1'b1, 1'b0);
        short_pkt = 1'b1; cyc(1); short_pkt = 1'b0; cyc(3);
        chk("R9 short ignored when disabled", eot_cnt, 0);
        rd(1'b1, v); chk("R9 still running", v & 1, 1);
        rd(1'b0, v); chk("R9 remaining untouched", v, 40);
        set_cfg(1'b0, 3, 6, 1'b1, 1'b0);
        cyc(2);

        // R10 abort in the middle of a transfer
        ep_level = 8'd255;
        set_count(100);
        clear_mon(100, 0, 0);
        set_cfg(1'b1, 0, 3, 1'b1, 1'b0);
        cyc(7);
        set_cfg(1'b0, 0, 3, 1'b1, 1'b0);
        cyc(3);
        chk("R10 dreq low after abort", int'(dreq), 0);
        chk("R10 one eot on abort", eot_cnt, 1);
        rd(1'b0, v); chk("R10 leftover count", v, 100 - bytes);

        // R11 bus reset keeps settings; R4 re-enable reloads
        set_count(50);
        clear_mon(50, 0, 0);
        set_cfg(1'b1, 0, 9, 1'b1, 1'b1);
        cyc(5);
        ep_level = 8'd0;
        cyc(3);
        rd(1'b0, v); chk("R7 remaining after partial move", v, 50 - bytes);
        bus_reset = 1'b1; cyc(1); bus_reset = 1'b0; cyc(2);
        chk("R11 no eot on bus reset", eot_cnt, 0);
        chk("R11 dreq low", int'(dreq), 0);
        rd(1'b1, v); chk("R11 settings kept, run clear", v, (1 << 9) | (1 << 8) | (9 << 4));
        wr(2'd3, 8'h03);   // staged low byte still carries enable=1
        rd(1'b0, v); chk("R4 reload on re-enable", v, 50);
        set_cfg(1'b0, 0, 9, 1'b1, 1'b1);

        // R2 torn write: low byte alone does not change the count
        wr(2'd0, 8'h07);
        set_cfg(1'b1, 0, 9, 1'b0, 1'b0);
        rd(1'b0, v); chk("R2 low byte alone ignored", v, 50);
        set_cfg(1'b0, 0, 9, 1'b0, 1'b0);
        wr(2'd1, 8'h00);
        set_cfg(1'b1, 0, 9, 1'b0, 1'b0);
        rd(1'b0, v); chk("R2 high byte commits", v, 7);
        set_cfg(1'b0, 0, 9, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule